// File: doc/BRIEF.md
# Multi-Channel Stream Link Bus Peripheral

This block connects a simple processor bus to a set of outbound (TX) and inbound (RX) 32-bit streaming channels. Each channel carries a valid/ready handshake and owns a private FIFO. Software pushes a word into a TX channel by writing that channel's data register. It pops a word from the matching RX channel by reading the same register. The TX FIFO drains onto its stream whenever the far side raises ready.

A control register holds one global enable bit and reports the configuration that was built: FIFO depths as log2 values and the channel counts. A status register gives per-channel fill flags, so software can poll before it touches a data register. If software skips the poll, a data access to a full TX FIFO or an empty RX FIFO withholds the bus acknowledge until the FIFO can serve it. While the enable bit is clear, every FIFO is held empty and both stream sides are idle.

Top module: `stream_link_hub`

## Requirements
- R1: After reset the enable bit is 0, `bus_ack` is low, every `tx_valid` and `rx_ready` bit is low, and a control read returns the configuration with bit 31 clear.
- R2: Control word: bit 31 is the read/write enable. Bits 30:16 read zero. Bits 15:12 hold log2 of the TX depth, 11:8 log2 of the RX depth, 7:4 the TX channel count and 3:0 the RX channel count. Writes to the read-only fields have no effect. Byte offsets 0x00 to 0x0F all select this register.
- R3: Status word (offsets 0x10 to 0x1F): bit 24+i is set when TX channel i holds more than half its depth (2*level > depth). Bit 16+i is set when RX channel i holds at least half its depth (2*level >= depth). Bit 8+i is set when TX channel i has a free entry. Bit i is set when RX channel i holds a word. Bits of unbuilt channels read 0.
- R4: Words written to data offset 0x20+4*i leave TX channel i in write order. A word moves on a cycle where `tx_valid[i]` and `tx_ready[i]` are both high.
- R5: A word enters RX channel i on a cycle where `rx_valid[i]` and `rx_ready[i]` are both high. Reads of offset 0x20+4*i return the words in arrival order.
- R6: A write to a TX channel whose FIFO is full holds off `bus_ack` until an entry frees up, and then completes.
- R7: A read of an RX channel whose FIFO is empty holds off `bus_ack` until a word arrives, and returns that word.
- R8: An unbuilt channel drives `tx_valid`, its `tx_data` slice and `rx_ready` low. A data access to it completes with the register latency, a read returns 0 and a write is discarded.
- R9: Clearing the enable bit empties every FIFO and holds `tx_valid` and `rx_ready` low. Words that were queued before the clear are not sent after the block is enabled again.
- R10: While disabled, a data access completes with the register latency. A read returns 0 and a write is discarded.
- R11: A request (`bus_we` or `bus_re` high for one cycle) is taken only when no access is pending. `bus_ack` is a one-cycle pulse. For a register access it rises on the second rising edge after the request is taken, and `bus_rdata` is valid while `bus_ack` is high.
- R12: While `tx_valid[i]` is high and `tx_ready[i]` is low, `tx_valid[i]` and the channel's `tx_data` slice stay unchanged unless the block is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset within the block; bits 1:0 ignored |
| bus_we | input | 1 | Write request pulse |
| bus_re | input | 1 | Read request pulse |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| tx_data | output | 256 | Eight 32-bit TX words, channel i at bits 32*i+31:32*i |
| tx_valid | output | 8 | TX word valid per channel |
| tx_ready | input | 8 | TX sink ready per channel |
| rx_data | input | 256 | Eight 32-bit RX words, channel i at bits 32*i+31:32*i |
| rx_valid | input | 8 | RX word valid per channel |
| rx_ready | output | 8 | RX FIFO can accept per channel |

## Verification
The hardest situation to reach from the ports is a data access that stays stalled for many cycles and then completes. The access has to arrive while its FIFO is at the full or empty boundary, and the stream side must stay silent until the bench releases it. The stimulus reaches this with directed steps. It holds all TX ready lines low, fills one TX channel to its depth while checking the status flags at each level, then launches a write and watches for twenty cycles that no acknowledge appears and the stalled stream word does not move, before it raises ready. The read stall is reached the same way: an empty RX channel is read and the word is supplied a dozen cycles later. A seeded random phase then interleaves reads, writes, ready patterns and source gaps to test ordering.

// File: rtl/slh_pkg.sv
// Package: shared constants and types for the stream link hub.
// Assumes a fixed 32-bit word and at most eight channels per direction.
package slh_pkg;
    localparam int MAX_CH   = 8;
    localparam int WORD_W   = 32;
    localparam int OFS_W    = 6;
    localparam int CHSEL_W  = 3;

    // Kind of register a pending bus access targets
    typedef enum logic [1:0] {
        ACC_CTRL = 2'd0,
        ACC_STAT = 2'd1,
        ACC_CHAN = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/slh_fifo.sv
// Module: single-clock FIFO for one stream channel.
// DEPTH must be a power of two. DEPTH==1 becomes a plain holding register.
// Assumes the user never pushes when full nor pops when empty.
module slh_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    generate
        if (DEPTH == 1) begin : g_reg
            logic [DW-1:0] hold_q;
            logic          vld_q;

            // Occupancy of the single slot
            always_ff @(posedge clk) begin
                if (!rst_n || clr) vld_q <= 1'b0;
                else if (push)     vld_q <= 1'b1;
                else if (pop)      vld_q <= 1'b0;
            end

            // Data of the single slot
            always_ff @(posedge clk) begin
                if (!rst_n)    hold_q <= '0;
                else if (push) hold_q <= wdata;
            end

            assign rdata = hold_q;
            assign empty = !vld_q;
            assign full  = vld_q;
            assign level = vld_q;
        end else begin : g_ram
            localparam int AW = $clog2(DEPTH);
            logic [DW-1:0] mem [DEPTH];
            logic [AW-1:0] wp_q, rp_q;
            logic [LW-1:0] cnt_q;

            // Storage write port
            always_ff @(posedge clk) begin
                if (push) mem[wp_q] <= wdata;
            end

            // Pointers and fill count
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    wp_q  <= '0;
                    rp_q  <= '0;
                    cnt_q <= '0;
                end else begin
                    if (push) wp_q <= wp_q + 1'b1;
                    if (pop)  rp_q <= rp_q + 1'b1;
                    case ({push, pop})
                        2'b10:   cnt_q <= cnt_q + 1'b1;
                        2'b01:   cnt_q <= cnt_q - 1'b1;
                        default: cnt_q <= cnt_q;
                    endcase
                end
            end

            assign rdata = mem[rp_q];
            assign empty = (cnt_q == '0);
            assign full  = (cnt_q == LW'(DEPTH));
            assign level = cnt_q;
        end
    endgenerate
endmodule

// File: rtl/slh_bus_port.sv
// Module: bus front end. It captures one request, holds it until the
// core grants it, then returns a one-cycle ack with registered read data.
// Assumes requests are one-cycle pulses; a request seen while one is
// pending is ignored. A write takes priority if both enables are high.
module slh_bus_port
    import slh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     in_addr,
    input  logic                 in_we,
    input  logic                 in_re,
    input  logic [WORD_W-1:0]    in_wdata,
    input  logic                 grant,
    input  logic [WORD_W-1:0]    grant_rdata,
    output logic                 pend,
    output logic                 pend_wr,
    output acc_kind_t            pend_kind,
    output logic [CHSEL_W-1:0]   pend_chan,
    output logic [WORD_W-1:0]    pend_wdata,
    output logic                 ack,
    output logic [WORD_W-1:0]    rdata
);
    logic [OFS_W-1:0] addr_q;
    logic             unused_lowbits;

    // Capture and retire the pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_wr    <= 1'b0;
            addr_q     <= '0;
            pend_wdata <= '0;
        end else if (!pend) begin
            if (in_we || in_re) begin
                pend       <= 1'b1;
                pend_wr    <= in_we;
                addr_q     <= in_addr;
                pend_wdata <= in_wdata;
            end
        end else if (grant) begin
            pend <= 1'b0;
        end
    end

    // Completion pulse and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= pend && grant;
            if (pend && grant) rdata <= pend_wr ? '0 : grant_rdata;
        end
    end

    // Offset decode of the held address
    always_comb begin
        if (addr_q[5])      pend_kind = ACC_CHAN;
        else if (addr_q[4]) pend_kind = ACC_STAT;
        else                pend_kind = ACC_CTRL;
    end

    assign pend_chan      = addr_q[4:2];
    assign unused_lowbits = ^addr_q[1:0];
endmodule

// File: rtl/slh_regs.sv
// Module: global enable register plus assembly of the read-only
// configuration word and the per-channel status word.
// Assumes channel counts of at most eight and depths of at most 32768.
module slh_regs
    import slh_pkg::*;
#(
    parameter int NUM_TX   = 3,
    parameter int NUM_RX   = 2,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic               wr_en_bit,
    input  logic [MAX_CH-1:0]  tx_free,
    input  logic [MAX_CH-1:0]  tx_half,
    input  logic [MAX_CH-1:0]  rx_avail,
    input  logic [MAX_CH-1:0]  rx_half,
    output logic               en,
    output logic [WORD_W-1:0]  ctrl_word,
    output logic [WORD_W-1:0]  stat_word
);
    localparam logic [3:0] TX_LOG = 4'($clog2(TX_DEPTH));
    localparam logic [3:0] RX_LOG = 4'($clog2(RX_DEPTH));
    localparam logic [3:0] TX_CNT = 4'(NUM_TX);
    localparam logic [3:0] RX_CNT = 4'(NUM_RX);

    // Global enable bit, written only through the control register
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= 1'b0;
        else if (wr_stb) en <= wr_en_bit;
    end

    assign ctrl_word = {en, 15'd0, TX_LOG, RX_LOG, TX_CNT, RX_CNT};
    assign stat_word = {tx_half, rx_half, tx_free, rx_avail};
endmodule

// File: rtl/stream_link_hub.sv
// Module: top of the stream link hub. It builds NUM_TX outbound and
// NUM_RX inbound channel FIFOs, arbitrates the single pending bus access
// against the FIFO state, and ties unbuilt channels low.
// Assumes power-of-two depths and counts between 0 and 8.
module stream_link_hub
    import slh_pkg::*;
#(
    parameter int NUM_TX   = 3,
    parameter int NUM_RX   = 2,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OFS_W-1:0]          bus_addr,
    input  logic                      bus_we,
    input  logic                      bus_re,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic                      bus_ack,
    output logic [MAX_CH*WORD_W-1:0]  tx_data,
    output logic [MAX_CH-1:0]         tx_valid,
    input  logic [MAX_CH-1:0]         tx_ready,
    input  logic [MAX_CH*WORD_W-1:0]  rx_data,
    input  logic [MAX_CH-1:0]         rx_valid,
    output logic [MAX_CH-1:0]         rx_ready
);
    localparam int TX_LW = $clog2(TX_DEPTH) + 1;
    localparam int RX_LW = $clog2(RX_DEPTH) + 1;

    logic                req_pending;
    logic                pend_wr;
    acc_kind_t           pend_kind;
    logic [CHSEL_W-1:0]  pend_chan;
    logic [WORD_W-1:0]   pend_wdata;
    logic                grant;
    logic [WORD_W-1:0]   grant_rdata;
    logic                en_q;
    logic [WORD_W-1:0]   ctrl_word, stat_word;
    logic [MAX_CH-1:0]   tx_free, tx_half, rx_avail, rx_half;
    logic [WORD_W-1:0]   rx_head [MAX_CH];
    logic                tx_built, rx_built, chan_ok;
    logic                svc_tx, svc_rx;

    slh_bus_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_addr     (bus_addr),
        .in_we       (bus_we),
        .in_re       (bus_re),
        .in_wdata    (bus_wdata),
        .grant       (grant),
        .grant_rdata (grant_rdata),
        .pend        (req_pending),
        .pend_wr     (pend_wr),
        .pend_kind   (pend_kind),
        .pend_chan   (pend_chan),
        .pend_wdata  (pend_wdata),
        .ack         (bus_ack),
        .rdata       (bus_rdata)
    );

    slh_regs #(
        .NUM_TX   (NUM_TX),
        .NUM_RX   (NUM_RX),
        .TX_DEPTH (TX_DEPTH),
        .RX_DEPTH (RX_DEPTH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (grant && pend_wr && (pend_kind == ACC_CTRL)),
        .wr_en_bit (pend_wdata[WORD_W-1]),
        .tx_free   (tx_free),
        .tx_half   (tx_half),
        .rx_avail  (rx_avail),
        .rx_half   (rx_half),
        .en        (en_q),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word)
    );

    // Decide whether the pending access can complete this cycle
    always_comb begin
        tx_built = int'(pend_chan) < NUM_TX;
        rx_built = int'(pend_chan) < NUM_RX;
        if (!en_q)        chan_ok = 1'b1;
        else if (pend_wr) chan_ok = !tx_built || tx_free[pend_chan];
        else              chan_ok = !rx_built || rx_avail[pend_chan];
        grant  = req_pending && ((pend_kind != ACC_CHAN) || chan_ok);
        svc_tx = grant && (pend_kind == ACC_CHAN) && pend_wr && en_q;
        svc_rx = grant && (pend_kind == ACC_CHAN) && !pend_wr && en_q;
    end

    // Select the word returned to the bus on a granted read
    always_comb begin
        case (pend_kind)
            ACC_CTRL: grant_rdata = ctrl_word;
            ACC_STAT: grant_rdata = stat_word;
            default:  grant_rdata = (en_q && rx_built) ? rx_head[pend_chan] : '0;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < MAX_CH; gi++) begin : g_tx
            if (gi < NUM_TX) begin : g_on
                logic             push_i, empty_i, full_i;
                logic [TX_LW-1:0] lvl_i;
                logic [WORD_W-1:0] head_i;

                assign push_i = svc_tx && (pend_chan == CHSEL_W'(gi));

                slh_fifo #(.DEPTH(TX_DEPTH), .DW(WORD_W)) u_fifo (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (!en_q),
                    .push  (push_i),
                    .wdata (pend_wdata),
                    .pop   (tx_valid[gi] && tx_ready[gi]),
                    .rdata (head_i),
                    .empty (empty_i),
                    .full  (full_i),
                    .level (lvl_i)
                );

                assign tx_valid[gi]                = en_q && !empty_i;
                assign tx_data[gi*WORD_W +: WORD_W] = head_i;
                assign tx_free[gi]                 = !full_i;
                assign tx_half[gi]                 = (int'(lvl_i) * 2) > TX_DEPTH;
            end else begin : g_off
                logic unused_tx_in;
                assign unused_tx_in                = tx_ready[gi];
                assign tx_valid[gi]                = 1'b0;
                assign tx_data[gi*WORD_W +: WORD_W] = '0;
                assign tx_free[gi]                 = 1'b0;
                assign tx_half[gi]                 = 1'b0;
            end
        end

        for (gi = 0; gi < MAX_CH; gi++) begin : g_rx
            if (gi < NUM_RX) begin : g_on
                logic             pop_i, empty_i, full_i;
                logic [RX_LW-1:0] lvl_i;

                assign pop_i = svc_rx && (pend_chan == CHSEL_W'(gi));

                slh_fifo #(.DEPTH(RX_DEPTH), .DW(WORD_W)) u_fifo (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (!en_q),
                    .push  (rx_valid[gi] && rx_ready[gi]),
                    .wdata (rx_data[gi*WORD_W +: WORD_W]),
                    .pop   (pop_i),
                    .rdata (rx_head[gi]),
                    .empty (empty_i),
                    .full  (full_i),
                    .level (lvl_i)
                );

                assign rx_ready[gi] = en_q && !full_i;
                assign rx_avail[gi] = !empty_i;
                assign rx_half[gi]  = (int'(lvl_i) * 2) >= RX_DEPTH;
            end else begin : g_off
                logic unused_rx_in;
                assign unused_rx_in = ^{rx_valid[gi], rx_data[gi*WORD_W +: WORD_W]};
                assign rx_head[gi]  = '0;
                assign rx_ready[gi] = 1'b0;
                assign rx_avail[gi] = 1'b0;
                assign rx_half[gi]  = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/slh_checker.sv
// Module: assertion checker bound to stream_link_hub. It observes the
// ports plus the enable bit and the pending-request flag.
module slh_checker #(
    parameter int NUM_TX = 3,
    parameter int NUM_RX = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_ack,
    input logic         req_pending,
    input logic         en_q,
    input logic [255:0] tx_data,
    input logic [7:0]   tx_valid,
    input logic [7:0]   tx_ready,
    input logic [7:0]   rx_ready
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R11

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(req_pending)); // R11

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (tx_valid == 8'd0 && rx_ready == 8'd0)); // R9

    genvar ci;
    generate
        for (ci = 0; ci < 8; ci++) begin : g_ch
            if (ci < NUM_TX) begin : g_tx_on
                AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (en_q && tx_valid[ci] && !tx_ready[ci]) |=>
                    (!en_q || (tx_valid[ci] && $stable(tx_data[ci*32 +: 32])))); // R12
            end else begin : g_tx_off
                AST_TX_UNBUILT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                    !tx_valid[ci] && (tx_data[ci*32 +: 32] == 32'd0)); // R8
            end
            if (ci >= NUM_RX) begin : g_rx_off
                AST_RX_UNBUILT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                    !rx_ready[ci]); // R8
            end
        end
    endgenerate
endmodule

bind stream_link_hub slh_checker #(
    .NUM_TX (NUM_TX),
    .NUM_RX (NUM_RX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ack     (bus_ack),
    .req_pending (req_pending),
    .en_q        (en_q),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready)
);

// File: tb/tb_stream_link_hub.sv
`timescale 1ns/1ps
module tb_stream_link_hub;
    localparam int NTX = 3;
    localparam int NRX = 2;
    localparam int TXD = 4;
    localparam int RXD = 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [5:0]   addr;
    logic         we, re;
    logic [31:0]  wdata, rdata;
    logic         ack;
    logic [255:0] tx_data;
    logic [7:0]   tx_valid, tx_ready;
    logic [255:0] rx_data;
    logic [7:0]   rx_valid, rx_ready;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] txm [NTX][256];
    int          txwi [NTX];
    int          txri [NTX];
    logic [31:0] rxm [NRX][64];
    int          rxwi [NRX];
    int          rxri [NRX];

    logic        rdy_mode = 1'b0;
    logic [2:0]  rdy_force = 3'b000;

    stream_link_hub #(
        .NUM_TX(NTX), .NUM_RX(NRX), .TX_DEPTH(TXD), .RX_DEPTH(RXD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(input logic en);
        return {en, 15'd0, 4'($clog2(TXD)), 4'($clog2(RXD)), 4'(NTX), 4'(NRX)};
    endfunction

    function automatic logic [31:0] exp_stat(input int t0, input int t1, input int t2,
                                             input int r0, input int r1);
        int tl [3];
        int rl [2];
        logic [31:0] s;
        tl[0] = t0; tl[1] = t1; tl[2] = t2;
        rl[0] = r0; rl[1] = r1;
        s = '0;
        for (int i = 0; i < 3; i++) begin
            if (tl[i] < TXD)     s[8 + i]  = 1'b1;
            if (tl[i] * 2 > TXD) s[24 + i] = 1'b1;
        end
        for (int i = 0; i < 2; i++) begin
            if (rl[i] > 0)        s[i]      = 1'b1;
            if (rl[i] * 2 >= RXD) s[16 + i] = 1'b1;
        end
        return s;
    endfunction

    task automatic bus_acc(input logic wr, input logic [5:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int lat);
        @(negedge clk);
        addr = a; we = wr; re = !wr; wdata = d; lat = 0;
        do begin
            @(negedge clk);
            we = 1'b0; re = 1'b0;
            lat++;
        end while (!ack);
        rd = rdata;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d, output int lat);
        logic [31:0] dummy;
        bus_acc(1'b1, a, d, dummy, lat);
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d, output int lat);
        bus_acc(1'b0, a, 32'd0, d, lat);
    endtask

    task automatic txw(input int ch, input logic [31:0] d);
        int lat;
        txm[ch][txwi[ch] % 256] = d;
        txwi[ch]++;
        bus_wr(6'(32 + 4 * ch), d, lat);
    endtask

    task automatic send_rx(input int ch, input logic [31:0] d);
        @(negedge clk);
        rx_valid[ch] = 1'b1;
        rx_data[ch*32 +: 32] = d;
        while (!rx_ready[ch]) @(negedge clk);
        rxm[ch][rxwi[ch] % 64] = d;
        rxwi[ch]++;
        @(negedge clk);
        rx_valid[ch] = 1'b0;
    endtask

    task automatic rx_read(input int ch);
        logic [31:0] d;
        int lat;
        bus_rd(6'(32 + 4 * ch), d, lat);
        chk(d == rxm[ch][rxri[ch] % 64], "R5 rx order", d, rxm[ch][rxri[ch] % 64]);
        rxri[ch]++;
    endtask

    // Drive TX ready at each falling edge
    always @(negedge clk) begin
        tx_ready = {5'd0, rdy_mode ? 3'($urandom) : rdy_force};
    end

    // Compare every TX stream transfer against the written words
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int i = 0; i < NTX; i++) begin
                if (tx_valid[i] && tx_ready[i]) begin
                    if (txri[i] == txwi[i]) begin
                        chk(1'b0, "R4 unexpected tx word", tx_data[i*32 +: 32], 32'd0);
                    end else begin
                        chk(tx_data[i*32 +: 32] == txm[i][txri[i] % 256], "R4 tx order",
                            tx_data[i*32 +: 32], txm[i][txri[i] % 256]);
                        txri[i]++;
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R11 watchdog expired", 32'(cyc), 32'd150000);
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        int          lat;
        bit          stall_bad;
        int unsigned seed_v;

        seed_v = $urandom(32'h1F2E3D4C);
        rst_n = 1'b0; addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
        rx_data = '0; rx_valid = '0;
        for (int i = 0; i < NTX; i++) begin txwi[i] = 0; txri[i] = 0; end
        for (int i = 0; i < NRX; i++) begin rxwi[i] = 0; rxri[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_valid == 8'd0 && rx_ready == 8'd0 && !ack, "R1 outputs idle",
            {16'd0, tx_valid, rx_ready}, 32'd0);
        bus_rd(6'h00, d, lat);
        chk(d == exp_ctrl(1'b0), "R1 control after reset", d, exp_ctrl(1'b0));
        bus_rd(6'h10, d, lat);
        chk(d == exp_stat(0, 0, 0, 0, 0), "R3 status empty", d, exp_stat(0, 0, 0, 0, 0));

        // R10 data access while disabled
        bus_wr(6'h20, 32'h1111_2222, lat);
        chk(lat == 2, "R10 disabled write latency", 32'(lat), 32'd2);
        @(negedge clk); #1;
        chk(tx_valid == 8'd0, "R10 disabled write discarded", {24'd0, tx_valid}, 32'd0);
        bus_rd(6'h24, d, lat);
        chk(d == 32'd0 && lat == 2, "R10 disabled read zero", d, 32'd0);

        // R2 enable and read-only fields
        bus_wr(6'h00, 32'hFFFF_FFFF, lat);
        bus_rd(6'h0C, d, lat);
        chk(d == exp_ctrl(1'b1), "R2 control mirror and read-only", d, exp_ctrl(1'b1));
        @(negedge clk); #1;
        chk(rx_ready == 8'b0000_0011, "R2 enable opens rx", {24'd0, rx_ready}, 32'h3);

        // R11 register latency and pulse width
        bus_rd(6'h04, d, lat);
        chk(lat == 2, "R11 register ack latency", 32'(lat), 32'd2);
        @(negedge clk);
        chk(!ack, "R11 ack single cycle", {31'd0, ack}, 32'd0);

        // R3 status flags across fill levels (TX ready held low)
        txw(1, 32'hA000_0000);
        txw(1, 32'hA000_0001);
        bus_rd(6'h10, d, lat);
        chk(d == exp_stat(0, 2, 0, 0, 0), "R3 tx half boundary", d, exp_stat(0, 2, 0, 0, 0));
        txw(1, 32'hA000_0002);
        bus_rd(6'h14, d, lat);
        chk(d == exp_stat(0, 3, 0, 0, 0), "R3 tx above half", d, exp_stat(0, 3, 0, 0, 0));
        send_rx(0, 32'h5555_0000);
        bus_rd(6'h10, d, lat);
        chk(d == exp_stat(0, 3, 0, 1, 0), "R3 rx word present", d, exp_stat(0, 3, 0, 1, 0));
        rx_read(0);
        txw(1, 32'hA000_0003);
        bus_rd(6'h10, d, lat);
        chk(d == exp_stat(0, 4, 0, 0, 0), "R3 tx full clears free", d, exp_stat(0, 4, 0, 0, 0));

        // R6 write to full TX channel stalls, R12 stream word held
        held = tx_data[63:32];
        stall_bad = 1'b0;
        fork
            txw(1, 32'hA000_0004);
            begin
                repeat (20) begin
                    @(negedge clk);
                    if (ack) stall_bad = 1'b1;
                end
                #1;
                chk(tx_valid[1] && tx_data[63:32] == held, "R12 stalled word held",
                    tx_data[63:32], held);
                rdy_force = 3'b010;
            end
        join
        chk(!stall_bad, "R6 no ack while full", {31'd0, stall_bad}, 32'd0);
        repeat (15) @(negedge clk);
        chk(txri[1] == txwi[1], "R4 channel drained", 32'(txri[1]), 32'(txwi[1]));

        // R7 read of empty RX channel stalls until a word arrives
        stall_bad = 1'b0;
        fork
            bus_rd(6'h24, d, lat);
            begin
                repeat (12) begin
                    @(negedge clk);
                    if (ack) stall_bad = 1'b1;
                end
                send_rx(1, 32'hCAFE_0001);
            end
        join
        rxri[1]++;
        chk(d == 32'hCAFE_0001 && !stall_bad, "R7 blocked read returns word", d, 32'hCAFE_0001);

        // R8 unbuilt channels
        bus_rd(6'h34, d, lat);
        chk(d == 32'd0 && lat == 2, "R8 unbuilt read", d, 32'd0);
        bus_wr(6'h38, 32'hDEAD_BEEF, lat);
        chk(lat == 2, "R8 unbuilt write latency", 32'(lat), 32'd2);
        rdy_force = 3'b111;
        repeat (4) @(negedge clk);
        #1;
        chk(tx_valid[7:3] == 5'd0 && tx_data[255:96] == '0, "R8 unbuilt tx low",
            {27'd0, tx_valid[7:3]}, 32'd0);
        chk(rx_ready[7:2] == 6'd0, "R8 unbuilt rx low", {26'd0, rx_ready[7:2]}, 32'd0);

        // R4/R5 seeded random traffic
        rdy_mode = 1'b1;
        fork
            begin
                for (int k = 0; k < 12; k++) begin
                    for (int c = 0; c < NRX; c++) begin
                        if ($urandom % 2 == 1) txw(int'($urandom % NTX), $urandom);
                        rx_read(c);
                    end
                end
            end
            begin
                for (int k = 0; k < 12; k++) begin
                    for (int c = 0; c < NRX; c++) begin
                        repeat ($urandom % 4) @(negedge clk);
                        send_rx(c, $urandom);
                    end
                end
            end
        join
        rdy_mode = 1'b0;
        rdy_force = 3'b111;
        repeat (30) @(negedge clk);
        for (int i = 0; i < NTX; i++)
            chk(txri[i] == txwi[i], "R4 all words delivered", 32'(txri[i]), 32'(txwi[i]));

        // R9 disable flushes queued words
        rdy_force = 3'b000;
        repeat (2) @(negedge clk);
        txw(0, 32'hB000_0000);
        txw(0, 32'hB000_0001);
        @(negedge clk); #1;
        chk(tx_valid[0], "R4 queued word offered", {31'd0, tx_valid[0]}, 32'd1);
        bus_wr(6'h00, 32'h0000_0000, lat);
        txri[0] = txwi[0];
        #1;
        chk(tx_valid == 8'd0 && rx_ready == 8'd0, "R9 disabled quiet",
            {16'd0, tx_valid, rx_ready}, 32'd0);
        bus_rd(6'h10, d, lat);
        chk(d == exp_stat(0, 0, 0, 0, 0), "R9 fifos flushed", d, exp_stat(0, 0, 0, 0, 0));
        bus_wr(6'h00, 32'h8000_0000, lat);
        rdy_force = 3'b111;
        repeat (5) @(negedge clk);
        #1;
        chk(tx_valid == 8'd0, "R9 nothing sent after re-enable", {24'd0, tx_valid}, 32'd0);

        summary();
    end
endmodule